// File: doc/BRIEF.md
# Flagged 16-bit Arithmetic/Logic Unit

This block is the integer ALU of a fixed-point datapath. On each enabled clock edge it takes two operand words, a 4-bit operation code and a carry selection. It then registers one result word together with four status flags: zero, negative, overflow and carry. Operands and results are plain bit patterns. Only the flags read meaning into them. Overflow is judged by two's-complement sign rules. Carry is judged by unsigned magnitude, so it can chain the words of a wider number.

Add-with-carry and subtract-with-borrow take their carry from a selectable source. One source is the block's own registered carry flag, which lets a 32-bit add or subtract run as two back-to-back word operations. The other is an external carry pin. The result and the flags always change together. They hold whenever the enable is low or the code is one of the reserved values. The block has no streaming data path: every pin is a plain control or status signal with no back-pressure, and one enabled operation completes on each clock edge.

Top module: `alu16_flagged`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `result` and all four flags to 0.
- R2: `result` and the flags update at a clock edge only when `op_en` is 1 and `op_code` is 0 to 11. When `op_en` is 0, or the code is 12 to 15, all of them keep their values.
- R3: Arithmetic codes give: 0 A+B, 1 A+B+cy, 2 A-B, 3 A-B-(1-cy), 4 0-A, 5 A, 6 A+1, 7 A-1. All results are taken modulo 2^16.
- R4: Bitwise codes give: 8 ~A, 9 A&B, 10 A|B, 11 A^B. For these codes, overflow and carry are cleared.
- R5: Carry for add-type codes (0, 1, 6) is the unsigned carry out of bit 15. For subtract-type codes (2, 3, 4, 7), carry is 1 exactly when no borrow occurs, that is when the unsigned minuend is at least the subtrahend plus any borrow-in. For pass (5), carry is 0.
- R6: Overflow is 1 exactly when the true signed result lies outside -32768..32767. Adding operands of opposite sign never sets it.
- R7: The zero flag is 1 exactly when all 16 result bits are 0. The negative flag equals result bit 15.
- R8: For codes 1 and 3, `cy` is the registered carry flag when `cin_sel` is 0, and the `carry_in` pin when `cin_sel` is 1.
- R9: A 32-bit add (code 0 then code 1) or subtract (code 2 then code 3), applied low word first with `cin_sel` 0, gives the correct 32-bit value.
- R10: Boundary cases of the unary codes are as follows. Negating 0x8000 sets overflow. Negating 0 sets carry. Incrementing 0xFFFF gives 0 with carry and zero set. Incrementing 0x7FFF sets overflow. Decrementing 0 clears carry. Decrementing 0x8000 sets overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_en | input | 1 | Perform the selected operation at this edge |
| op_code | input | 4 | Operation code (0-11 valid, 12-15 reserved) |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| carry_in | input | 1 | External carry for codes 1 and 3 |
| cin_sel | input | 1 | 0: use stored carry flag, 1: use `carry_in` |
| result | output | 16 | Registered result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry / no-borrow flag |

## Verification
Additions are driven with same-sign and mixed-sign operand pairs. This separates the signed overflow rule from the unsigned carry rule, since some pairs set one flag but not the other. Subtractions with the minuend above, equal to and below the subtrahend show whether carry means "no borrow". Each unary code is driven at its wrap points (0, 0x7FFF, 0x8000, 0xFFFF), where a wrong flag shows up as a single bit. Chained 32-bit add and subtract sequences, and runs with each carry source, confirm which carry value feeds codes 1 and 3.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_NEG  = 4'd4,
    OP_PASS = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_NOT  = 4'd8,
    OP_AND  = 4'd9,
    OP_OR   = 4'd10,
    OP_XOR  = 4'd11
  } alu_op_e;

  localparam int unsigned OP_LAST = 11;

  // left adder input source
  typedef enum logic {
    XS_A    = 1'b0,
    XS_ZERO = 1'b1
  } x_src_e;

  // right adder input source
  typedef enum logic [2:0] {
    YS_B     = 3'd0,
    YS_NOT_B = 3'd1,
    YS_NOT_A = 3'd2,
    YS_ZERO  = 3'd3,
    YS_ONES  = 3'd4
  } y_src_e;

  typedef enum logic [1:0] {
    LG_NOT = 2'd0,
    LG_AND = 2'd1,
    LG_OR  = 2'd2,
    LG_XOR = 2'd3
  } logic_sel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } alu_flags_t;

  typedef struct packed {
    logic       valid;
    logic       is_logic;
    x_src_e     x_src;
    y_src_e     y_src;
    logic       cin;
    logic_sel_e lsel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
(
  input  logic [3:0] op_code,
  input  logic       stored_c,
  input  logic       carry_in,
  input  logic       cin_sel,
  output alu_ctrl_t  ctrl
);

  logic chain_c;

  // carry source for the chained codes
  assign chain_c = cin_sel ? carry_in : stored_c;

  always_comb begin
    ctrl          = '0;
    ctrl.x_src    = XS_A;
    ctrl.y_src    = YS_ZERO;
    ctrl.lsel     = logic_sel_e'(op_code[1:0]);
    ctrl.valid    = (int'(op_code) <= OP_LAST);
    ctrl.is_logic = op_code[3] && ctrl.valid;
    case (op_code)
      OP_ADD:  begin ctrl.y_src = YS_B;                              ctrl.cin = 1'b0;    end
      OP_ADC:  begin ctrl.y_src = YS_B;                              ctrl.cin = chain_c; end
      OP_SUB:  begin ctrl.y_src = YS_NOT_B;                          ctrl.cin = 1'b1;    end
      OP_SBB:  begin ctrl.y_src = YS_NOT_B;                          ctrl.cin = chain_c; end
      OP_NEG:  begin ctrl.x_src = XS_ZERO; ctrl.y_src = YS_NOT_A;    ctrl.cin = 1'b1;    end
      OP_PASS: begin ctrl.y_src = YS_ZERO;                           ctrl.cin = 1'b0;    end
      OP_INC:  begin ctrl.y_src = YS_ZERO;                           ctrl.cin = 1'b1;    end
      OP_DEC:  begin ctrl.y_src = YS_ONES;                           ctrl.cin = 1'b0;    end
      default: begin ctrl.y_src = YS_ZERO;                           ctrl.cin = 1'b0;    end
    endcase
  end

endmodule

// File: rtl/alu16_adder.sv
module alu16_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W:0] cy;

  assign cy[0] = cin;

  // ripple chain, one full adder per bit
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = x[i] ^ y[i] ^ cy[i];
    assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
  end

  assign cout = cy[W];
  // signed overflow: carry into the MSB differs from carry out of it
  assign ovf  = cy[W] ^ cy[W-1];

endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise
  import alu16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   lsel,
  output logic [W-1:0] y
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (lsel)
        LG_NOT:  y[i] = ~a[i];
        LG_AND:  y[i] = a[i] & b[i];
        LG_OR:   y[i] = a[i] | b[i];
        default: y[i] = a[i] ^ b[i];
      endcase
    end
  end

endmodule

// File: rtl/alu16_flagged.sv
module alu16_flagged
  import alu16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_en,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  input  logic         cin_sel,
  output logic [W-1:0] result,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_c
);

  localparam int unsigned MSB = W - 1;

  alu_ctrl_t  ctrl;
  alu_flags_t flags_q, flags_d;
  logic [W-1:0] res_q, res_d;
  logic [W-1:0] add_x, add_y, add_sum, lg_y;
  logic         add_c, add_v;
  logic         load;

  alu16_decode u_decode (
    .op_code  (op_code),
    .stored_c (flags_q.c),
    .carry_in (carry_in),
    .cin_sel  (cin_sel),
    .ctrl     (ctrl)
  );

  always_comb begin
    add_x = (ctrl.x_src == XS_ZERO) ? '0 : opnd_a;
    case (ctrl.y_src)
      YS_B:     add_y = opnd_b;
      YS_NOT_B: add_y = ~opnd_b;
      YS_NOT_A: add_y = ~opnd_a;
      YS_ONES:  add_y = '1;
      default:  add_y = '0;
    endcase
  end

  alu16_adder #(.W(W)) u_adder (
    .x    (add_x),
    .y    (add_y),
    .cin  (ctrl.cin),
    .sum  (add_sum),
    .cout (add_c),
    .ovf  (add_v)
  );

  alu16_bitwise #(.W(W)) u_bitwise (
    .a    (opnd_a),
    .b    (opnd_b),
    .lsel (ctrl.lsel),
    .y    (lg_y)
  );

  always_comb begin
    res_d     = ctrl.is_logic ? lg_y : add_sum;
    flags_d.z = (res_d == '0);
    flags_d.n = res_d[MSB];
    flags_d.v = ctrl.is_logic ? 1'b0 : add_v;
    flags_d.c = ctrl.is_logic ? 1'b0 : add_c;
  end

  assign load = op_en && ctrl.valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (load) begin
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

  assign result = res_q;
  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (result == '0 && !flag_z && !flag_n && !flag_v && !flag_c)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !op_en |=> ($stable(result) && $stable({flag_z, flag_n, flag_v, flag_c}))); // R2
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst) (op_en && op_code[3] && op_code[2]) |=> ($stable(result) && $stable({flag_z, flag_n, flag_v, flag_c}))); // R2
  AST_LOGIC_CLEARS_VC: assert property (@(posedge clk) disable iff (rst) (op_en && op_code[3] && !op_code[2]) |=> (!flag_v && !flag_c)); // R4
  AST_NO_OVF_MIXED_ADD: assert property (@(posedge clk) disable iff (rst) (op_en && op_code == OP_ADD && opnd_a[MSB] != opnd_b[MSB]) |=> !flag_v); // R6
  AST_ZN_MATCH: assert property (@(posedge clk) disable iff (rst) (op_en && int'(op_code) <= OP_LAST) |=> (flag_z == (result == '0) && flag_n == result[MSB])); // R7
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst) (op_en && op_code == OP_INC && opnd_a == '1) |=> (flag_c && flag_z)); // R10

endmodule

// File: tb/test_alu16_flagged.sv
`timescale 1ns/1ps
module test_alu16_flagged;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_en = 1'b0;
  logic [3:0]  op_code = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic        carry_in = 1'b0, cin_sel = 1'b0;
  logic [15:0] result;
  logic        flag_z, flag_n, flag_v, flag_c;

  int n_tests = 0;
  int n_fail  = 0;
  logic [19:0] exp_st = '0;   // {c, v, n, z, result}

  always #4 clk = ~clk;

  alu16_flagged i_alu16_flagged (
    .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .cin_sel(cin_sel),
    .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c)
  );

  // reference from the requirements, using wide integer arithmetic
  function automatic logic [19:0] model(logic [3:0] op, logic [15:0] a, logic [15:0] b, logic cy);
    integer ua, ub, sa, sb, ur, sr, bw;
    logic [15:0] r;
    logic v, c;
    ua = {16'b0, a}; ub = {16'b0, b};
    sa = $signed(a); sb = $signed(b);
    bw = cy ? 0 : 1;
    ur = 0; sr = 0; c = 1'b0; r = '0;
    case (op)
      4'd0: begin ur = ua + ub;      sr = sa + sb;      c = (ur > 65535); end
      4'd1: begin ur = ua + ub + (1 - bw); sr = sa + sb + (1 - bw); c = (ur > 65535); end
      4'd2: begin ur = ua - ub;      sr = sa - sb;      c = (ur >= 0); end
      4'd3: begin ur = ua - ub - bw; sr = sa - sb - bw; c = (ur >= 0); end
      4'd4: begin ur = 0 - ua;       sr = 0 - sa;       c = (ur >= 0); end
      4'd5: begin ur = ua;           sr = sa;           c = 1'b0; end
      4'd6: begin ur = ua + 1;       sr = sa + 1;       c = (ur > 65535); end
      4'd7: begin ur = ua - 1;       sr = sa - 1;       c = (ur >= 0); end
      default: ;
    endcase
    v = (sr > 32767) || (sr < -32768);
    r = ur[15:0];
    case (op)
      4'd8:  begin r = ~a;    v = 1'b0; c = 1'b0; end
      4'd9:  begin r = a & b; v = 1'b0; c = 1'b0; end
      4'd10: begin r = a | b; v = 1'b0; c = 1'b0; end
      4'd11: begin r = a ^ b; v = 1'b0; c = 1'b0; end
      default: ;
    endcase
    return {c, v, r[15], (r == 16'h0), r};
  endfunction

  function automatic logic [19:0] observed();
    return {flag_c, flag_v, flag_n, flag_z, result};
  endfunction

  task automatic check(string req, logic [19:0] got, logic [19:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got c%0b v%0b n%0b z%0b res=%04h, expected c%0b v%0b n%0b z%0b res=%04h",
               req, got[19], got[18], got[17], got[16], got[15:0],
               exp[19], exp[18], exp[17], exp[16], exp[15:0]);
    end
  endtask

  // drive one operation at a falling edge, sample at the next falling edge
  task automatic apply(string req, logic en, logic [3:0] op, logic [15:0] a, logic [15:0] b,
                       logic ci, logic sel);
    logic cy;
    @(negedge clk);
    op_en = en; op_code = op; opnd_a = a; opnd_b = b; carry_in = ci; cin_sel = sel;
    cy = sel ? ci : exp_st[19];
    if (en && op <= 4'd11) exp_st = model(op, a, b, cy);
    @(negedge clk);
    op_en = 1'b0;
    check(req, observed(), exp_st);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_st = '0;
    check("R1 reset state", observed(), 20'h0);
  endtask

  task automatic t_add();
    apply("R3 add plain",            1, 4'd0, 16'h1234, 16'h0111, 0, 0);
    apply("R6 add pos+pos overflow", 1, 4'd0, 16'h7FFF, 16'h0001, 0, 0);
    apply("R6 add neg+neg overflow", 1, 4'd0, 16'h8000, 16'hFFFF, 0, 0);
    apply("R6 add mixed no overflow",1, 4'd0, 16'h7FFF, 16'h8000, 0, 0);
    apply("R5 add unsigned carry",   1, 4'd0, 16'hFFFF, 16'h0002, 0, 0);
    apply("R7 add to zero",          1, 4'd0, 16'h8000, 16'h8000, 0, 0);
    if (!(flag_c && flag_v && flag_z)) begin n_tests++; n_fail++; $display("FAIL R5 R6 R7: c%0b v%0b z%0b expected 1 1 1", flag_c, flag_v, flag_z); end
    else n_tests++;
  endtask

  task automatic t_sub();
    apply("R5 sub a>b no borrow",    1, 4'd2, 16'h0009, 16'h0003, 0, 0);
    apply("R5 sub a==b zero",        1, 4'd2, 16'h4444, 16'h4444, 0, 0);
    apply("R5 sub a<b borrow",       1, 4'd2, 16'h0003, 16'h0009, 0, 0);
    apply("R6 sub overflow",         1, 4'd2, 16'h8000, 16'h0001, 0, 0);
    apply("R6 sub pos-neg overflow", 1, 4'd2, 16'h7FFF, 16'hFFFF, 0, 0);
  endtask

  task automatic t_logic();
    apply("R3 set carry first",  1, 4'd0, 16'hFFFF, 16'hFFFF, 0, 0);
    apply("R4 not",              1, 4'd8, 16'h0F0F, 16'h0000, 0, 0);
    apply("R4 and",              1, 4'd9, 16'hF0F0, 16'hFF00, 0, 0);
    apply("R4 or",               1, 4'd10, 16'h00F0, 16'h0F00, 0, 0);
    apply("R4 xor to zero",      1, 4'd11, 16'hA5A5, 16'hA5A5, 0, 0);
  endtask

  task automatic t_unary();
    apply("R10 neg 8000",  1, 4'd4, 16'h8000, 16'h0, 0, 0);
    apply("R10 neg 0",     1, 4'd4, 16'h0000, 16'h0, 0, 0);
    apply("R3 neg 1",      1, 4'd4, 16'h0001, 16'h0, 0, 0);
    apply("R5 pass",       1, 4'd5, 16'h8001, 16'h0, 0, 0);
    apply("R10 inc ffff",  1, 4'd6, 16'hFFFF, 16'h0, 0, 0);
    apply("R10 inc 7fff",  1, 4'd6, 16'h7FFF, 16'h0, 0, 0);
    apply("R10 dec 0",     1, 4'd7, 16'h0000, 16'h0, 0, 0);
    apply("R10 dec 8000",  1, 4'd7, 16'h8000, 16'h0, 0, 0);
  endtask

  task automatic t_hold();
    apply("R2 setup",           1, 4'd0, 16'h0100, 16'h0023, 0, 0);
    apply("R2 enable low hold", 0, 4'd11, 16'hFFFF, 16'h0000, 0, 0);
    apply("R2 reserved 12",     1, 4'd12, 16'hFFFF, 16'h1111, 1, 1);
    apply("R2 reserved 15",     1, 4'd15, 16'h8000, 16'h8000, 1, 1);
  endtask

  task automatic t_cin_sel();
    apply("R8 clear carry",        1, 4'd0, 16'h0001, 16'h0001, 0, 0);
    apply("R8 adc port carry",     1, 4'd1, 16'h0005, 16'h0003, 1, 1);
    apply("R8 adc stored carry",   1, 4'd1, 16'h0005, 16'h0003, 1, 0);
    apply("R8 set carry",          1, 4'd0, 16'hFFFF, 16'h0001, 0, 0);
    apply("R8 sbb port no borrow", 1, 4'd3, 16'h0005, 16'h0003, 0, 1);
    apply("R8 sbb stored carry",   1, 4'd3, 16'h0005, 16'h0003, 1, 0);
  endtask

  task automatic t_chain32();
    logic [15:0] lo;
    apply("R9 add low",  1, 4'd0, 16'hFFFF, 16'h0001, 0, 0);
    lo = result;
    apply("R9 adc high", 1, 4'd1, 16'h0001, 16'h0000, 0, 0);
    check("R9 32-bit sum", {4'h0, result, lo}, 20'h20000);
    apply("R9 sub low",  1, 4'd2, 16'h0000, 16'h0001, 0, 0);
    lo = result;
    apply("R9 sbb high", 1, 4'd3, 16'h0002, 16'h0000, 0, 0);
    check("R9 32-bit diff", {4'h0, result, lo}, 20'h1FFFF);
  endtask

  task automatic t_reset_mid();
    apply("R1 load nonzero", 1, 4'd0, 16'hFFFF, 16'h8000, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_st = '0;
    check("R1 reset after use", observed(), 20'h0);
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_unary();
    t_hold();
    t_cin_sel();
    t_chain32();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule